// File: doc/BRIEF.md
# Bilinear Interpolating Calibration Table

This block turns a pair of raw 8-bit converter codes into a single calibrated fixed-point value. A typical pair is engine speed and manifold pressure. Each code is moved onto a grid axis by linear scaling. The scaling subtracts a per-axis origin, takes the upper bits as the cell index, and keeps the lower bits as a fractional weight. The grid is a constant table built at elaboration time. The block fetches the four cells around the input point and blends them with weights taken from both fractions. The blended value is rounded to the output width.

The grid is three times finer than a coarse calibration map. The row axis has 13 breakpoints, 16 codes apart, starting at code 16. The column axis has 7 breakpoints, 32 codes apart, starting at code 0. The pipeline has two register stages. One sits after address generation and the cell fetch, and one after the blend. It can accept a new point on every clock.

Both the input pair and the result travel on valid/ready streams. A point is taken when `in_valid` and `in_ready` are both high at a clock edge. A result is taken when `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the whole pipeline freezes and `in_ready` drops. No point is lost and no result is repeated.

Top module: `bli_table`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `in_ready` is 1 until the first accepted point has moved through the pipeline.
- R2: Row position p = x − 16. Row index is p >> 4 and row fraction fx is p & 15. Column index is y >> 5 and column fraction fy is y & 31.
- R3: With row index i, column index j, SX = 16 and SY = 32, the result is ((SX−fx)(SY−fy)·C[i][j] + fx(SY−fy)·C[i+1][j] + (SX−fx)fy·C[i][j+1] + fx·fy·C[i+1][j+1] + 256) >> 9, so halves round up.
- R4: A row code of 208 or more selects row 12 with fx = 0. A column code of 192 or more selects column 6 with fy = 0. The result then equals the edge cells along that axis.
- R5: A row code below 16 selects row 0 with fx = 0.
- R6: A point accepted at clock edge k gives `out_valid` high after edge k+1. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged.
- R7: The constant cell at row i, column j holds 100 + 40·i + 7·j² + 3·i·j, with 0 ≤ i ≤ 12 and 0 ≤ j ≤ 6.
- R8: A point exactly on a breakpoint in both axes (fx = 0 and fy = 0) returns that cell's value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_x | input | 8 | Row-axis converter code |
| in_y | input | 8 | Column-axis converter code |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take the input pair |
| out_data | output | 12 | Interpolated result |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink can take the result |

## Verification
A stall can land in the same cycle as a new point arriving. In that cycle the output stage holds a result while the stage behind it also holds a fetched point and another pair waits at the input. The bench drives `in_valid` high while it pulls `out_ready` low for several cycles, both in a directed burst and at random. The cycle-accurate reference model must then match the frozen result, the dropped `in_ready`, and the exact order and values of every result released afterwards.

// File: rtl/bli_pkg.sv
package bli_pkg;

  // Constant calibration surface, evaluated at elaboration time only.
  function automatic int unsigned cal_cell(int unsigned row, int unsigned col);
    return 100 + 40 * row + 7 * col * col + 3 * row * col;
  endfunction

endpackage

// File: rtl/bli_axis.sv
// Linear scaling of one converter code onto a grid axis.
module bli_axis #(
  parameter int CODE_W = 8,
  parameter int FRAC_W = 4,
  parameter int ORIGIN = 16,
  parameter int NPTS   = 13,
  localparam int IDX_W = (NPTS > 1) ? $clog2(NPTS) : 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  idx_lo,
  output logic [IDX_W-1:0]  idx_hi,
  output logic [FRAC_W-1:0] frac
);
  localparam int SEG_W = CODE_W - FRAC_W;
  localparam logic [CODE_W-1:0] ORG  = CODE_W'(ORIGIN);
  localparam logic [SEG_W-1:0]  LAST = SEG_W'(NPTS - 1);
  localparam logic [IDX_W-1:0]  EDGE = IDX_W'(NPTS - 1);

  logic [CODE_W-1:0] ofs;
  logic [SEG_W-1:0]  seg;

  always_comb begin
    ofs    = code - ORG;
    seg    = ofs[CODE_W-1:FRAC_W];
    idx_lo = '0;
    idx_hi = '0;
    frac   = '0;
    if (code < ORG) begin
      idx_lo = '0;
      idx_hi = '0;
    end else if (seg >= LAST) begin
      idx_lo = EDGE;
      idx_hi = EDGE;
    end else begin
      idx_lo = IDX_W'(seg);
      idx_hi = IDX_W'(seg + 1'b1);
      frac   = ofs[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/bli_cell_rom.sv
// Constant grid and the four-cell fetch.
module bli_cell_rom #(
  parameter int NX     = 13,
  parameter int NY     = 7,
  parameter int CELL_W = 12,
  localparam int IX_W  = (NX > 1) ? $clog2(NX) : 1,
  localparam int IY_W  = (NY > 1) ? $clog2(NY) : 1
) (
  input  logic [IX_W-1:0]   ix_lo,
  input  logic [IX_W-1:0]   ix_hi,
  input  logic [IY_W-1:0]   iy_lo,
  input  logic [IY_W-1:0]   iy_hi,
  output logic [CELL_W-1:0] c_ll,
  output logic [CELL_W-1:0] c_hl,
  output logic [CELL_W-1:0] c_lh,
  output logic [CELL_W-1:0] c_hh
);
  logic [CELL_W-1:0] grid [NX][NY];

  for (genvar gi = 0; gi < NX; gi++) begin : g_row
    for (genvar gj = 0; gj < NY; gj++) begin : g_col
      assign grid[gi][gj] = CELL_W'(bli_pkg::cal_cell(gi, gj));
    end
  end

  always_comb begin
    c_ll = grid[ix_lo][iy_lo];
    c_hl = grid[ix_hi][iy_lo];
    c_lh = grid[ix_lo][iy_hi];
    c_hh = grid[ix_hi][iy_hi];
  end
endmodule

// File: rtl/bli_blend.sv
// Weighted four-cell blend with round-half-up and output clamp.
module bli_blend #(
  parameter int CELL_W = 12,
  parameter int FX_W   = 4,
  parameter int FY_W   = 5,
  parameter int OUT_W  = 12
) (
  input  logic [CELL_W-1:0] c_ll,
  input  logic [CELL_W-1:0] c_hl,
  input  logic [CELL_W-1:0] c_lh,
  input  logic [CELL_W-1:0] c_hh,
  input  logic [FX_W-1:0]   fx,
  input  logic [FY_W-1:0]   fy,
  output logic [OUT_W-1:0]  result
);
  localparam int FW    = FX_W + FY_W;
  localparam int SUM_W = CELL_W + FW + 2;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (FW - 1);
  localparam logic [SUM_W-1:0] OMAX = SUM_W'({OUT_W{1'b1}});

  logic [FX_W:0]      wx_lo, wx_hi;
  logic [FY_W:0]      wy_lo, wy_hi;
  logic [SUM_W-1:0]   t_ll, t_hl, t_lh, t_hh, acc, scaled;

  always_comb begin
    wx_hi  = {1'b0, fx};
    wx_lo  = {1'b1, {FX_W{1'b0}}} - wx_hi;
    wy_hi  = {1'b0, fy};
    wy_lo  = {1'b1, {FY_W{1'b0}}} - wy_hi;
    t_ll   = SUM_W'(c_ll) * SUM_W'(wx_lo) * SUM_W'(wy_lo);
    t_hl   = SUM_W'(c_hl) * SUM_W'(wx_hi) * SUM_W'(wy_lo);
    t_lh   = SUM_W'(c_lh) * SUM_W'(wx_lo) * SUM_W'(wy_hi);
    t_hh   = SUM_W'(c_hh) * SUM_W'(wx_hi) * SUM_W'(wy_hi);
    acc    = t_ll + t_hl + t_lh + t_hh + HALF;
    scaled = acc >> FW;
    if (scaled > OMAX) result = {OUT_W{1'b1}};
    else               result = OUT_W'(scaled);
  end
endmodule

// File: rtl/bli_table.sv
// Two-stage bilinear calibration lookup with valid/ready streams.
module bli_table #(
  parameter int CODE_W   = 8,
  parameter int X_FRAC   = 4,
  parameter int X_ORIGIN = 16,
  parameter int X_PTS    = 13,
  parameter int Y_FRAC   = 5,
  parameter int Y_ORIGIN = 0,
  parameter int Y_PTS    = 7,
  parameter int CELL_W   = 12,
  parameter int OUT_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] in_x,
  input  logic [CODE_W-1:0] in_y,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int IX_W = (X_PTS > 1) ? $clog2(X_PTS) : 1;
  localparam int IY_W = (Y_PTS > 1) ? $clog2(Y_PTS) : 1;

  logic [IX_W-1:0]   ix_lo, ix_hi;
  logic [IY_W-1:0]   iy_lo, iy_hi;
  logic [X_FRAC-1:0] fx_now;
  logic [Y_FRAC-1:0] fy_now;
  logic [CELL_W-1:0] f_ll, f_hl, f_lh, f_hh;
  logic              advance;

  // stage 1 state
  logic              s1_valid;
  logic [CELL_W-1:0] s1_ll, s1_hl, s1_lh, s1_hh;
  logic [X_FRAC-1:0] s1_fx;
  logic [Y_FRAC-1:0] s1_fy;
  logic [OUT_W-1:0]  blended;

  bli_axis #(.CODE_W(CODE_W), .FRAC_W(X_FRAC), .ORIGIN(X_ORIGIN), .NPTS(X_PTS)) u_ax_x (
    .code(in_x), .idx_lo(ix_lo), .idx_hi(ix_hi), .frac(fx_now)
  );

  bli_axis #(.CODE_W(CODE_W), .FRAC_W(Y_FRAC), .ORIGIN(Y_ORIGIN), .NPTS(Y_PTS)) u_ax_y (
    .code(in_y), .idx_lo(iy_lo), .idx_hi(iy_hi), .frac(fy_now)
  );

  bli_cell_rom #(.NX(X_PTS), .NY(Y_PTS), .CELL_W(CELL_W)) u_rom (
    .ix_lo(ix_lo), .ix_hi(ix_hi), .iy_lo(iy_lo), .iy_hi(iy_hi),
    .c_ll(f_ll), .c_hl(f_hl), .c_lh(f_lh), .c_hh(f_hh)
  );

  bli_blend #(.CELL_W(CELL_W), .FX_W(X_FRAC), .FY_W(Y_FRAC), .OUT_W(OUT_W)) u_blend (
    .c_ll(s1_ll), .c_hl(s1_hl), .c_lh(s1_lh), .c_hh(s1_hh),
    .fx(s1_fx), .fy(s1_fy), .result(blended)
  );

  // whole pipeline moves together; it freezes only when a result is refused
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (advance) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && in_valid) begin
      s1_ll <= f_ll;
      s1_hl <= f_hl;
      s1_lh <= f_lh;
      s1_hh <= f_hh;
      s1_fx <= fx_now;
      s1_fy <= fy_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= blended;
    end
  end
endmodule

// File: rtl/bli_table_chk.sv
// Protocol and range checks, bound to every bli_table instance.
module bli_table_chk #(
  parameter int OUT_W  = 12,
  parameter int LO_VAL = 0,
  parameter int HI_VAL = 4095
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_valid,
  input logic             out_ready
);
  a_r6_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r6_ready_follows_sink: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  a_r6_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  a_r3_within_table: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data >= OUT_W'(LO_VAL) && out_data <= OUT_W'(HI_VAL)));
endmodule

bind bli_table bli_table_chk #(
  .OUT_W (OUT_W),
  .LO_VAL(int'(bli_pkg::cal_cell(0, 0))),
  .HI_VAL(int'(bli_pkg::cal_cell(X_PTS - 1, Y_PTS - 1)))
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/bli_table_test.sv
module bli_table_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_x = '0;
  logic [7:0] in_y = '0;
  logic       in_valid = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready;
  logic [11:0] out_data;
  logic       out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bli_table uut (
    .clk(clk), .rst_n(rst_n), .in_x(in_x), .in_y(in_y), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  function automatic int ref_cell(int r, int c);
    return 100 + 40 * r + 7 * c * c + 3 * r * c;
  endfunction

  function automatic int ref_out(int x, int y);
    int px, ix, fx, ix1, iy, fy, iy1, s;
    px = (x < 16) ? 0 : x - 16;
    ix = px / 16; fx = px % 16;
    if (ix >= 12) begin ix = 12; fx = 0; end
    ix1 = (ix == 12) ? 12 : ix + 1;
    iy = y / 32; fy = y % 32;
    if (iy >= 6) begin iy = 6; fy = 0; end
    iy1 = (iy == 6) ? 6 : iy + 1;
    s = (16 - fx) * (32 - fy) * ref_cell(ix, iy) + fx * (32 - fy) * ref_cell(ix1, iy)
      + (16 - fx) * fy * ref_cell(ix, iy1) + fx * fy * ref_cell(ix1, iy1);
    return (s + 256) / 512;
  endfunction

  function automatic string ref_tag(int x, int y);
    if (x < 16) return "R5";
    if (x >= 208 || y >= 192) return "R4";
    if ((x - 16) % 16 == 0 && y % 32 == 0) return "R8 R7";
    return "R2 R3";
  endfunction

  // reference pipeline state
  bit    m1_v, m2_v;
  int    m1_d, m2_d;
  string m1_t, m2_t;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1_v <= 1'b0;
      m2_v <= 1'b0;
    end else if (!m2_v || out_ready) begin
      m1_v <= in_valid;
      if (in_valid) begin
        m1_d <= ref_out(in_x, in_y);
        m1_t <= ref_tag(in_x, in_y);
      end
      m2_v <= m1_v;
      if (m1_v) begin
        m2_d <= m1_d;
        m2_t <= m1_t;
      end
    end
  end

  task automatic compare();
    checks++;
    if (out_valid !== m2_v) begin
      fails++;
      $display("FAIL R6 out_valid actual=%0b expected=%0b", out_valid, m2_v);
    end
    checks++;
    if (in_ready !== (!m2_v || out_ready)) begin
      fails++;
      $display("FAIL R6 in_ready actual=%0b expected=%0b", in_ready, (!m2_v || out_ready));
    end
    if (m2_v) begin
      checks++;
      if (out_data !== 12'(m2_d)) begin
        fails++;
        $display("FAIL %s out_data actual=%0d expected=%0d", m2_t, out_data, m2_d);
      end
    end
  endtask

  task automatic step(int x, int y, bit v, bit rdy);
    @(negedge clk);
    compare();
    in_x = 8'(x); in_y = 8'(y); in_valid = v; out_ready = rdy;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset state actual v=%0b r=%0b expected v=0 r=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 1);
    // R8/R7 breakpoints
    step(16, 0, 1, 1);
    step(208 - 16, 160, 1, 1);
    step(208, 192, 1, 1);
    step(48, 64, 1, 1);
    // R2/R3 interior, half weights and odd weights
    step(24, 16, 1, 1);
    step(100, 77, 1, 1);
    step(31, 31, 1, 1);
    step(201, 191, 1, 1);
    // R4 saturation on each axis and both
    step(255, 255, 1, 1);
    step(230, 40, 1, 1);
    step(90, 250, 1, 1);
    // R5 low clamp
    step(0, 0, 1, 1);
    step(15, 100, 1, 1);
    step(3, 255, 1, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    // R6 stall burst with fresh points pending
    step(60, 60, 1, 0);
    step(70, 70, 1, 0);
    step(80, 80, 1, 0);
    step(90, 90, 1, 0);
    step(90, 90, 1, 1);
    step(110, 12, 1, 0);
    step(110, 12, 1, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    // random traffic with random back-pressure
    for (int k = 0; k < 600; k++) begin
      step(int'($urandom_range(255)), int'($urandom_range(255)),
           bit'($urandom_range(3) != 0), bit'($urandom_range(3) != 0));
    end
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule